// File: doc/BRIEF.md
# Two-Buffer Burst Store Queue

This block collects outgoing data in two 32-byte staging buffers, each of eight 32-bit words, and sends a whole buffer to external memory as a single wide burst when told to. Software fills the slots one word at a time through a small register port and may read any slot back. A flush command carries an address: one bit of it picks the buffer, and the rest forms the burst target.

The target is formed in one of two ways. When the flush command says the address is already external (translation active), the target is that address cut to 29 bits and aligned down to 32 bytes. Otherwise the low part of the target comes from the flush address, and a small per-buffer control register supplies the upper bits. The burst leaves on a master port with a valid/ready handshake and carries all 256 data bits in one beat. While a buffer is being sent, writes to that buffer are stalled; the other buffer stays open.

Top module: `stq_pair`

## Requirements
- R1: After reset `busy` and `bw_valid` are 0, `fl_ready` and `reg_ready` are 1, every slot reads back as 0 and both control registers hold 0.
- R2: A write with `reg_wr` high and `reg_ready` high stores `reg_wdata` in the slot chosen by `reg_addr[5:2]` (16 slots; bits 1:0 are ignored). A read with `reg_rd` high returns that slot on `reg_rdata` one cycle later.
- R3: `reg_addr[5]` and `fl_addr[5]` choose the buffer: 0 means slots 0 to 7, 1 means slots 8 to 15. In a burst, word k of the chosen buffer sits on `bw_data[32k+31:32k]`.
- R4: With `fl_xlat` low, `bw_addr` has bits 25:5 from `fl_addr`, the chosen buffer's 5-bit control value ORed in at bits 28:24, and bits 4:0 and 31:29 at 0.
- R5: With `fl_xlat` high, `bw_addr` equals `fl_addr[28:5]` at bits 28:5 with bits 4:0 and 31:29 at 0.
- R6: A write with `ctl_wr` high sets the control register selected by `ctl_idx` to `ctl_wdata` and leaves the other one unchanged; the value at the moment a flush is accepted is the one used.
- R7: A flush accepted at a clock edge raises `bw_valid` in the following cycle; until `bw_ready` is seen, `bw_valid`, `bw_addr` and `bw_data` stay unchanged.
- R8: `busy` is 1 from the edge a flush is accepted until the edge its burst handshake completes; `fl_ready` is low while `busy` is high, so a second flush waits.
- R9: While a buffer's burst is pending, `reg_ready` is low for writes to that buffer and such a write changes nothing; writes to the other buffer are accepted.
- R10: Each accepted flush produces exactly one burst: `bw_valid` is 0 in the cycle after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Slot write request |
| reg_rd | input | 1 | Slot read request |
| reg_addr | input | 6 | Byte address of the slot |
| reg_wdata | input | 32 | Slot write data |
| reg_ready | output | 1 | Write can be taken this cycle |
| reg_rdata | output | 32 | Slot read data, one cycle after the request |
| ctl_wr | input | 1 | Control register write |
| ctl_idx | input | 1 | Buffer whose control register is written |
| ctl_wdata | input | 5 | Upper target bits for that buffer |
| fl_valid | input | 1 | Flush request |
| fl_ready | output | 1 | Flush can be accepted |
| fl_addr | input | 32 | Flush address (buffer select and target) |
| fl_xlat | input | 1 | Flush address is already external |
| busy | output | 1 | A burst is outstanding |
| bw_valid | output | 1 | Burst request valid |
| bw_ready | input | 1 | Burst accepted by memory |
| bw_addr | output | 32 | Burst target, 32-byte aligned |
| bw_data | output | 256 | Whole buffer, word 0 in the low bits |

## Verification
A slot write is visible to a read issued in the next cycle, and read data is due one clock after the read request, so the bench drives on the falling edge and samples the following falling edge. A flush accepted at edge n shows `bw_valid`, its address and its data from edge n, so the bench checks them at the first falling edge after acceptance and again at every stalled cycle, each against a word image kept by the bench. After the handshake edge, `bw_valid` and `busy` are checked low at the next falling edge; a write stalled against the flushed buffer is expected to land only at the edge after that handshake, and a read-back confirms it.

// File: rtl/stq_pkg.sv
package stq_pkg;
   // physical burst address width and upper-bit placement
   localparam int STQ_PHYS_W  = 29;
   localparam int STQ_CTL_LSB = 24;
   localparam int STQ_KEEP_HI = 25;
endpackage

// File: rtl/stq_bank.sv
module stq_bank #(
   parameter int WORD_W = 32,
   parameter int LANES  = 8,
   localparam int IDX_W = $clog2(LANES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [IDX_W-1:0]          widx,
   input  logic [WORD_W-1:0]         wdata,
   output logic [LANES*WORD_W-1:0]   line
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n) word_q <= '0;
         else if (we && (widx == IDX_W'(k))) word_q <= wdata;
      end
      assign line[k*WORD_W +: WORD_W] = word_q;
   end
endmodule

// File: rtl/stq_flush_ctl.sv
module stq_flush_ctl
   import stq_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int CTL_W    = 5,
   parameter int NUM_BUFS = 2,
   parameter int ALIGN    = 5,
   localparam int BUF_W   = $clog2(NUM_BUFS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      fl_valid,
   input  logic [ADDR_W-1:0]         fl_addr,
   input  logic                      fl_xlat,
   input  logic [NUM_BUFS*CTL_W-1:0] ctl_flat,
   input  logic                      bw_ready,
   output logic                      fl_ready,
   output logic                      busy,
   output logic [ADDR_W-1:0]         bw_addr,
   output logic [BUF_W-1:0]          cur_buf
);
   localparam logic [ADDR_W-1:0] PHYS_MASK  = ADDR_W'((64'd1 << STQ_PHYS_W) - 64'd1);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((64'd1 << ALIGN) - 64'd1);
   localparam logic [ADDR_W-1:0] KEEP_MASK  =
      ADDR_W'((64'd1 << (STQ_KEEP_HI + 1)) - 64'd1) & ALIGN_MASK;

   logic [BUF_W-1:0]  sel_buf;
   logic [CTL_W-1:0]  sel_ctl;
   logic [ADDR_W-1:0] target;
   logic              accept;

   assign sel_buf = fl_addr[ALIGN +: BUF_W];
   assign sel_ctl = ctl_flat[sel_buf*CTL_W +: CTL_W];
   assign fl_ready = !busy;
   assign accept   = fl_valid && !busy;

   always_comb begin
      if (fl_xlat) target = fl_addr & ALIGN_MASK & PHYS_MASK;
      else         target = ((fl_addr & KEEP_MASK) |
                             (ADDR_W'(sel_ctl) << STQ_CTL_LSB)) & PHYS_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         bw_addr <= '0;
         cur_buf <= '0;
      end else if (accept) begin
         busy    <= 1'b1;
         bw_addr <= target;
         cur_buf <= sel_buf;
      end else if (busy && bw_ready) begin
         busy    <= 1'b0;
      end
   end
endmodule

// File: rtl/stq_pair.sv
module stq_pair
   import stq_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int LANES    = 8,
   parameter int NUM_BUFS = 2,
   parameter int ADDR_W   = 32,
   parameter int CTL_W    = 5,
   parameter int READ_LAT = 1
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        reg_wr,
   input  logic                                        reg_rd,
   input  logic [$clog2(NUM_BUFS*LANES*WORD_W/8)-1:0]  reg_addr,
   input  logic [WORD_W-1:0]                           reg_wdata,
   output logic                                        reg_ready,
   output logic [WORD_W-1:0]                           reg_rdata,
   input  logic                                        ctl_wr,
   input  logic [$clog2(NUM_BUFS)-1:0]                 ctl_idx,
   input  logic [CTL_W-1:0]                            ctl_wdata,
   input  logic                                        fl_valid,
   output logic                                        fl_ready,
   input  logic [ADDR_W-1:0]                           fl_addr,
   input  logic                                        fl_xlat,
   output logic                                        busy,
   output logic                                        bw_valid,
   input  logic                                        bw_ready,
   output logic [ADDR_W-1:0]                           bw_addr,
   output logic [LANES*WORD_W-1:0]                     bw_data
);
   localparam int BYTE_LSB = $clog2(WORD_W/8);
   localparam int IDX_W    = $clog2(LANES);
   localparam int BUF_W    = $clog2(NUM_BUFS);
   localparam int ALIGN    = BYTE_LSB + IDX_W;
   localparam int REG_AW   = ALIGN + BUF_W;
   localparam int BURST_W  = LANES*WORD_W;

   // elaboration-time parameter checks
   if (WORD_W % 8 != 0 || (1 << BYTE_LSB) * 8 != WORD_W) begin : g_bad_word
      $error("WORD_W must be a power-of-two number of bytes");
   end
   if ((1 << IDX_W) != LANES || LANES < 2) begin : g_bad_lanes
      $error("LANES must be a power of two, at least 2");
   end
   if ((1 << BUF_W) != NUM_BUFS || NUM_BUFS < 2) begin : g_bad_bufs
      $error("NUM_BUFS must be a power of two, at least 2");
   end
   if (ALIGN > STQ_KEEP_HI || STQ_CTL_LSB + CTL_W > STQ_PHYS_W || STQ_PHYS_W > ADDR_W) begin : g_bad_addr
      $error("address field layout does not fit ADDR_W");
   end
   if (READ_LAT != 0 && READ_LAT != 1) begin : g_bad_lat
      $error("READ_LAT must be 0 or 1");
   end

   logic [IDX_W-1:0]        a_lane;
   logic [BUF_W-1:0]        a_buf;
   logic [BUF_W-1:0]        cur_buf;
   logic                    wr_go;
   logic [BURST_W-1:0]      bank_line [NUM_BUFS];
   logic [NUM_BUFS*CTL_W-1:0] ctl_flat;
   logic [WORD_W-1:0]       rd_word;

   assign a_lane    = reg_addr[BYTE_LSB +: IDX_W];
   assign a_buf     = reg_addr[ALIGN +: BUF_W];
   assign reg_ready = !(busy && (a_buf == cur_buf));
   assign wr_go     = reg_wr && reg_ready;

   for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
      stq_bank #(.WORD_W(WORD_W), .LANES(LANES)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_go && (a_buf == BUF_W'(b))),
         .widx  (a_lane),
         .wdata (reg_wdata),
         .line  (bank_line[b])
      );

      logic [CTL_W-1:0] ctl_q;
      always_ff @(posedge clk) begin
         if (!rst_n) ctl_q <= '0;
         else if (ctl_wr && (ctl_idx == BUF_W'(b))) ctl_q <= ctl_wdata;
      end
      assign ctl_flat[b*CTL_W +: CTL_W] = ctl_q;
   end

   stq_flush_ctl #(
      .ADDR_W(ADDR_W), .CTL_W(CTL_W), .NUM_BUFS(NUM_BUFS), .ALIGN(ALIGN)
   ) u_flush (
      .clk      (clk),
      .rst_n    (rst_n),
      .fl_valid (fl_valid),
      .fl_addr  (fl_addr),
      .fl_xlat  (fl_xlat),
      .ctl_flat (ctl_flat),
      .bw_ready (bw_ready),
      .fl_ready (fl_ready),
      .busy     (busy),
      .bw_addr  (bw_addr),
      .cur_buf  (cur_buf)
   );

   assign bw_valid = busy;
   assign bw_data  = bank_line[cur_buf];
   assign rd_word  = bank_line[a_buf][a_lane*WORD_W +: WORD_W];

   if (READ_LAT == 0) begin : g_rd_comb
      assign reg_rdata = rd_word;
   end else begin : g_rd_reg
      logic [WORD_W-1:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rdata_q <= '0;
         else if (reg_rd) rdata_q <= rd_word;
      end
      assign reg_rdata = rdata_q;
   end
endmodule

// File: rtl/stq_pair_chk.sv
module stq_pair_chk #(
   parameter int ADDR_W  = 32,
   parameter int BURST_W = 256,
   parameter int ALIGN   = 5,
   parameter int PHYS_W  = 29
) (
   input logic               clk,
   input logic               rst_n,
   input logic               fl_valid,
   input logic               fl_ready,
   input logic               busy,
   input logic               bw_valid,
   input logic               bw_ready,
   input logic [ADDR_W-1:0]  bw_addr,
   input logic [BURST_W-1:0] bw_data,
   input logic               reg_ready
);
   a_r7_hold_burst: assert property (@(posedge clk) disable iff (!rst_n)
      (bw_valid && !bw_ready) |=> (bw_valid && $stable(bw_addr) && $stable(bw_data)));

   a_r8_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_valid && fl_ready) |=> busy);

   a_r8_busy_only_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(fl_valid));

   a_r10_one_burst: assert property (@(posedge clk) disable iff (!rst_n)
      (bw_valid && bw_ready) |=> !bw_valid);

   a_r4_aligned_target: assert property (@(posedge clk) disable iff (!rst_n)
      bw_valid |-> (bw_addr[ALIGN-1:0] == '0 && bw_addr[ADDR_W-1:PHYS_W] == '0));

   a_r9_idle_writable: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> reg_ready);
endmodule

bind stq_pair stq_pair_chk #(
   .ADDR_W(ADDR_W), .BURST_W(BURST_W), .ALIGN(ALIGN), .PHYS_W(stq_pkg::STQ_PHYS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fl_valid(fl_valid), .fl_ready(fl_ready),
   .busy(busy), .bw_valid(bw_valid), .bw_ready(bw_ready), .bw_addr(bw_addr),
   .bw_data(bw_data), .reg_ready(reg_ready)
);

// File: tb/stq_pair_tb.sv
module stq_pair_tb;
   logic         clk = 0;
   logic         rst_n = 0;
   logic         reg_wr = 0, reg_rd = 0;
   logic [5:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic         reg_ready;
   logic [31:0]  reg_rdata;
   logic         ctl_wr = 0;
   logic [0:0]   ctl_idx = '0;
   logic [4:0]   ctl_wdata = '0;
   logic         fl_valid = 0;
   logic         fl_ready;
   logic [31:0]  fl_addr = '0;
   logic         fl_xlat = 0;
   logic         busy, bw_valid;
   logic         bw_ready = 0;
   logic [31:0]  bw_addr;
   logic [255:0] bw_data;

   int n_chk = 0, n_err = 0;
   bit done = 0;
   logic [31:0] m_slot [16];
   logic [4:0]  m_ctl [2];

   always #5 clk = ~clk;

   stq_pair u_dut (.*);

   task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_tgt(logic [31:0] a, logic x, logic [4:0] c);
      if (x) return {3'b0, a[28:5], 5'b0};
      return {3'b0, c, 24'b0} | {6'b0, a[25:5], 5'b0};
   endfunction

   function automatic logic [255:0] exp_line(logic b);
      logic [255:0] d;
      for (int k = 0; k < 8; k++) d[32*k +: 32] = m_slot[{b, 3'(k)}];
      return d;
   endfunction

   task automatic do_write(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
      m_slot[a[5:2]] = d;
   endtask

   task automatic do_read(logic [5:0] a, string tag);
      @(negedge clk);
      reg_rd = 1; reg_addr = a;
      @(negedge clk);
      reg_rd = 0;
      chk(tag, 256'(reg_rdata), 256'(m_slot[a[5:2]]));
   endtask

   task automatic do_ctl(logic i, logic [4:0] v);
      @(negedge clk);
      ctl_wr = 1; ctl_idx = i; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 0;
      m_ctl[i] = v;
   endtask

   // flush, hold the burst off for 'stall' cycles, then accept it
   task automatic do_flush(logic [31:0] a, logic x, int stall, string tag);
      logic [31:0]  ea;
      logic [255:0] ed;
      @(negedge clk);
      chk({tag, " R8 fl_ready idle"}, 256'(fl_ready), 256'(1));
      fl_valid = 1; fl_addr = a; fl_xlat = x;
      ea = exp_tgt(a, x, m_ctl[a[5]]);
      ed = exp_line(a[5]);
      @(negedge clk);
      fl_valid = 0;
      chk({tag, " R7 bw_valid"}, 256'(bw_valid), 256'(1));
      chk({tag, " R8 busy/fl_ready"}, 256'({busy, fl_ready}), 256'(2'b10));
      chk({tag, x ? " R5 addr" : " R4 addr"}, 256'(bw_addr), 256'(ea));
      chk({tag, " R3 data"}, bw_data, ed);
      for (int s = 0; s < stall; s++) begin
         @(negedge clk);
         chk({tag, " R7 held"}, {bw_data[223:0], bw_addr}, {ed[223:0], ea});
      end
      bw_ready = 1;
      @(negedge clk);
      bw_ready = 0;
      chk({tag, " R10 single burst"}, 256'({bw_valid, busy}), 256'(0));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 16; i++) m_slot[i] = '0;
      m_ctl[0] = '0; m_ctl[1] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 outputs", 256'({busy, bw_valid, fl_ready, reg_ready}), 256'(4'b0011));
      do_read(6'h0c, "R1 slot3 zero");
      do_read(6'h3c, "R1 slot15 zero");
      do_flush(32'h0000_0020, 0, 0, "R1 ctl zero");

      // R2 write/read, low address bits ignored
      do_write(6'h05, 32'hdead_beef);
      do_read(6'h04, "R2 slot1");
      do_write(6'h23, 32'h1234_5678);
      do_read(6'h20, "R2 slot8");
      // R3 buffer select, full lines
      for (int k = 0; k < 16; k++) do_write(6'(k*4), 32'h0100_0000 * k + 32'h55);
      do_flush(32'h0123_4540, 0, 1, "R3 buf0");
      do_flush(32'h0123_4560, 0, 0, "R3 buf1");
      // R6 per-buffer control
      do_ctl(1, 5'h1f);
      do_ctl(0, 5'h0a);
      do_flush(32'hffff_ffe0, 0, 0, "R6 buf1 ctl1f");
      do_flush(32'h03ff_ffc4, 0, 2, "R6 buf0 ctl0a");
      // R5 translated
      do_flush(32'hfedc_ba9f, 1, 0, "R5 xlat");
      do_flush(32'h1fff_ffc0, 1, 1, "R5 xlat top");

      // R9 write to flushing buffer is stalled
      do_write(6'h08, 32'haaaa_0001);
      @(negedge clk);
      fl_valid = 1; fl_addr = 32'h0000_1000; fl_xlat = 0;
      @(negedge clk);
      fl_valid = 0;
      reg_wr = 1; reg_addr = 6'h08; reg_wdata = 32'hbbbb_0002;
      #1;
      chk("R9 stall same buffer", 256'(reg_ready), 256'(0));
      @(negedge clk);
      chk("R9 burst data untouched", 256'(bw_data[95:64]), 256'(32'haaaa_0001));
      chk("R8 second flush waits", 256'(fl_ready), 256'(0));
      bw_ready = 1;
      @(negedge clk);
      bw_ready = 0;
      chk("R9 ready after burst", 256'(reg_ready), 256'(1));
      @(negedge clk);
      reg_wr = 0;
      m_slot[2] = 32'hbbbb_0002;
      do_read(6'h08, "R9 stalled write lands");

      // R9 other buffer writable during burst
      @(negedge clk);
      fl_valid = 1; fl_addr = 32'h0000_2000;
      @(negedge clk);
      fl_valid = 0;
      reg_wr = 1; reg_addr = 6'h24; reg_wdata = 32'hcccc_0003;
      #1;
      chk("R9 other buffer ready", 256'(reg_ready), 256'(1));
      @(negedge clk);
      reg_wr = 0;
      m_slot[9] = 32'hcccc_0003;
      bw_ready = 1;
      @(negedge clk);
      bw_ready = 0;
      do_read(6'h24, "R9 other buffer written");

      // random mix
      for (int it = 0; it < 120; it++) begin
         int op = $urandom_range(0, 3);
         case (op)
            0: do_write(6'($urandom), $urandom);
            1: do_read(6'($urandom), "R2 random read");
            2: do_ctl(1'($urandom), 5'($urandom));
            default: do_flush($urandom, 1'($urandom), $urandom_range(0, 3), "rand");
         endcase
      end

      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule